// File: doc/BRIEF.md
# Downlink Gold Scrambling Code Generator

This block produces the complex downlink scrambling sequence for a W-CDMA base station: one I chip and one Q chip for every clock on which the chip enable is high. Two 18-stage linear feedback shift registers run side by side. The primary register uses one feedback tap set and the companion register uses a richer one. The I chip is the XOR of the low stage of each register. The Q chip is the XOR of a fixed group of stages from each register. This is the usual Gold-code construction.

A restart pulse samples a 9-bit code number n, which selects one of 512 codes. On restart the companion register is set to all ones. The primary register is set to a base state with only stage 0 set, and is then stepped n times before the first chip. The block raises `busy` during this walk, and its chip outputs stay quiet. The state reached after the walk is kept. When the frame of 38,400 chips ends, the sequence restarts from that state at once, with no new walk. A frame marker goes high together with chip 0 of every frame. The outputs are raw bits. The consumer maps 0 to +1 and 1 to -1.

Top module: `dl_scram_gen`

## Requirements
- R1: After reset `busy` is 0 and the block generates code 0 from chip 0, so the first enabled chip has `frame_start`=1, `chip_i`=0 and `chip_q`=0.
- R2: Registers shift towards stage 0, and the feedback enters stage 17. The primary register feeds back stage 0 XOR stage 7. The companion register feeds back the XOR of stages 0, 5, 7 and 10. `chip_i` is stage 0 of the primary register XOR stage 0 of the companion register.
- R3: `chip_q` is the XOR of primary stages 4, 6 and 15 with companion stages 5, 6, 8, 9, 10, 11, 12, 13, 14 and 15.
- R4: A clock edge with `restart` high loads the companion register with all ones and the primary register with 1 in stage 0 only, and resets the chip count to 0. `restart` wins over `chip_en` in the same cycle, so no chip is consumed in that cycle.
- R5: After a restart edge that samples `code_num`=n, `busy` is high for exactly n cycles, whatever `chip_en` does. In each of those cycles the primary register steps once and the companion register holds.
- R6: While `busy` is high, `chip_i`, `chip_q` and `frame_start` are all 0.
- R7: A cycle with `chip_en` low, `busy` low and no restart leaves the sequence and chip count unchanged.
- R8: `frame_start` is high exactly in cycles where `chip_en` is high, `busy` is low, there is no restart, and the chip about to be consumed is chip 0 of the frame.
- R9: After chip 38,399 is consumed, the next chip is chip 0 of the same code again. This restart does not raise `busy`.
- R10: `code_num` is ignored except on a clock edge with `restart` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Consume one chip this cycle |
| restart | input | 1 | Restart pulse; samples `code_num` |
| code_num | input | 9 | Code selection, 0 to 511 |
| chip_i | output | 1 | I chip, valid when `chip_en` is high and `busy` is low |
| chip_q | output | 1 | Q chip, same validity as `chip_i` |
| frame_start | output | 1 | High alongside chip 0 of each frame |
| busy | output | 1 | Code offset walk in progress |

## Verification
The chip outputs and `frame_start` depend combinationally on register state and `chip_en`. They therefore belong to the same cycle in which the chip is consumed. `busy` rises in the first cycle after the restart edge and falls n cycles later. The bench drives inputs on the falling edge and samples all outputs 1 ns later. It advances its own model of both registers, the chip count and the remaining walk once per rising edge, so each comparison is against the state that the coming edge will consume. A full frame of code 0 is run to reach the wrap at chip 38,399. Random codes, gaps in `chip_en`, restarts in mid-walk and a drifting `code_num` cover the rest.

// File: rtl/scram_pkg.sv
package scram_pkg;
   localparam int unsigned REG_W = 18;
   // feedback masks, stage k at bit k
   localparam logic [REG_W-1:0] PRI_FB_MASK  = 18'h00081;   // stages 0,7
   localparam logic [REG_W-1:0] CMP_FB_MASK  = 18'h004A1;   // stages 0,5,7,10
   // Q branch selection masks
   localparam logic [REG_W-1:0] PRI_Q_MASK   = 18'h08050;   // stages 4,6,15
   localparam logic [REG_W-1:0] CMP_Q_MASK   = 18'h0FF60;   // stages 5,6,8..15
   localparam logic [REG_W-1:0] PRI_BASE     = 18'h00001;
   localparam logic [REG_W-1:0] CMP_BASE     = 18'h3FFFF;
endpackage

// File: rtl/scram_lfsr.sv
module scram_lfsr #(
   parameter int unsigned W = 18,
   parameter logic [W-1:0] FB_MASK = '1,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] q,
   output logic [W-1:0] q_adv
);
   if (W < 2) begin : g_bad_w
      $error("scram_lfsr: W must be at least 2");
   end
   if (FB_MASK[0] == 1'b0) begin : g_bad_mask
      $error("scram_lfsr: feedback mask must include stage 0");
   end
   if (RST_VAL == '0) begin : g_bad_rst
      $error("scram_lfsr: reset value must be nonzero");
   end

   logic fb;
   assign fb = ^(q & FB_MASK);

   for (genvar g = 0; g < W - 1; g++) begin : g_shift
      assign q_adv[g] = q[g+1];
   end
   assign q_adv[W-1] = fb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= load_val;
      else if (step) q <= q_adv;
   end

   // R2
   nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);
endmodule

// File: rtl/scram_ctrl.sv
module scram_ctrl #(
   parameter int unsigned CODE_W    = 9,
   parameter int unsigned FRAME_LEN = 38400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              restart,
   input  logic [CODE_W-1:0] code_num,
   output logic              busy,
   output logic              fire,
   output logic              wrap,
   output logic              cap_seed,
   output logic              first_chip
);
   localparam int unsigned CNT_W = $clog2(FRAME_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   if (FRAME_LEN < 2) begin : g_bad_len
      $error("scram_ctrl: FRAME_LEN must be at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("scram_ctrl: CODE_W must be at least 1");
   end

   logic [CODE_W-1:0] adv_q;
   logic [CNT_W-1:0]  cnt_q;

   assign busy       = (adv_q != '0);
   assign fire       = chip_en & ~busy & ~restart;
   assign wrap       = fire & (cnt_q == LAST);
   assign cap_seed   = busy & ~restart & (adv_q == CODE_W'(1));
   assign first_chip = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adv_q <= '0;
         cnt_q <= '0;
      end else if (restart) begin
         adv_q <= code_num;
         cnt_q <= '0;
      end else begin
         if (busy) adv_q <= adv_q - CODE_W'(1);
         if (fire) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      end
   end

   // R5
   walk_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !restart |=> adv_q == $past(adv_q) - CODE_W'(1));
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !restart && !busy && !chip_en |=> $stable(cnt_q));
   // R9
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt_q == '0 && !busy);
endmodule

// File: rtl/dl_scram_gen.sv
module dl_scram_gen
   import scram_pkg::*;
#(
   parameter int unsigned CODE_W    = 9,
   parameter int unsigned FRAME_LEN = 38400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              restart,
   input  logic [CODE_W-1:0] code_num,
   output logic              chip_i,
   output logic              chip_q,
   output logic              frame_start,
   output logic              busy
);
   logic fire, wrap, cap_seed, first_chip;
   logic [REG_W-1:0] x_q, x_adv, y_q, y_adv, seed_q, x_load_val;
   logic x_load, y_load, x_step;

   scram_ctrl #(.CODE_W(CODE_W), .FRAME_LEN(FRAME_LEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .restart(restart),
      .code_num(code_num), .busy(busy), .fire(fire), .wrap(wrap),
      .cap_seed(cap_seed), .first_chip(first_chip)
   );

   assign x_load     = restart | wrap;
   assign x_load_val = restart ? PRI_BASE : seed_q;
   assign x_step     = busy | fire;
   assign y_load     = restart | wrap;

   scram_lfsr #(.W(REG_W), .FB_MASK(PRI_FB_MASK), .RST_VAL(PRI_BASE)) u_pri (
      .clk(clk), .rst_n(rst_n), .load(x_load), .load_val(x_load_val),
      .step(x_step), .q(x_q), .q_adv(x_adv)
   );

   scram_lfsr #(.W(REG_W), .FB_MASK(CMP_FB_MASK), .RST_VAL(CMP_BASE)) u_cmp (
      .clk(clk), .rst_n(rst_n), .load(y_load), .load_val(CMP_BASE),
      .step(fire), .q(y_q), .q_adv(y_adv)
   );

   // chip-0 state of the selected code, kept for frame wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             seed_q <= PRI_BASE;
      else if (restart && code_num == '0)     seed_q <= PRI_BASE;
      else if (cap_seed)                      seed_q <= x_adv;
   end

   assign chip_i      = ~busy & (x_q[0] ^ y_q[0]);
   assign chip_q      = ~busy & ((^(x_q & PRI_Q_MASK)) ^ (^(y_q & CMP_Q_MASK)));
   assign frame_start = fire & first_chip;

   // R6
   quiet_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !chip_i && !chip_q && !frame_start);
   // R5
   cmp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !restart |=> $stable(y_q));
   // R4
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> y_q == CMP_BASE && (busy || x_q == PRI_BASE));
endmodule

// File: tb/sim_dl_scram_gen.sv
`timescale 1ns/100ps
module sim_dl_scram_gen;
   localparam int LEN = 38400;
   logic clk = 0, rst_n = 0, chip_en = 0, restart = 0;
   logic [8:0] code_num = '0;
   logic chip_i, chip_q, frame_start, busy;
   int n_tests = 0, n_fail = 0, n_cyc = 0;

   dl_scram_gen u0 (.clk(clk), .rst_n(rst_n), .chip_en(chip_en), .restart(restart),
      .code_num(code_num), .chip_i(chip_i), .chip_q(chip_q),
      .frame_start(frame_start), .busy(busy));

   always #2.5 clk = ~clk;

   logic [17:0] mx, my, mseed;
   int mcnt, mleft;

   function automatic logic [17:0] nx(input logic [17:0] v);
      return {v[0] ^ v[7], v[17:1]};
   endfunction
   function automatic logic [17:0] ny(input logic [17:0] v);
      return {v[0] ^ v[5] ^ v[7] ^ v[10], v[17:1]};
   endfunction
   function automatic logic qbit(input logic [17:0] a, input logic [17:0] b);
      logic r;
      r = a[4] ^ a[6] ^ a[15] ^ b[5] ^ b[6];
      for (int k = 8; k <= 15; k++) r = r ^ b[k];
      return r;
   endfunction

   task automatic chk(input logic act, input logic exp, input string req, input string ph);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (phase %s) cycle %0d: actual %0b expected %0b", req, ph, n_cyc, act, exp);
      end
   endtask

   task automatic cyc(input logic en, input logic rs, input logic [8:0] code, input string ph);
      logic mbusy, mfire;
      @(negedge clk);
      chip_en = en; restart = rs; code_num = code;
      #1;
      n_cyc++;
      mbusy = (mleft != 0);
      mfire = en && !mbusy && !rs;
      chk(busy, mbusy, "R5", ph);
      if (mbusy) begin
         chk(chip_i | chip_q | frame_start, 1'b0, "R6", ph);
      end else begin
         chk(frame_start, mfire && mcnt == 0, "R8", ph);
         if (mfire) begin
            chk(chip_i, mx[0] ^ my[0], "R2", ph);
            chk(chip_q, qbit(mx, my), "R3", ph);
         end
      end
      if (rs) begin
         mx = 18'h1; my = '1; mcnt = 0; mleft = code;
         mseed = 18'h1;
         for (int k = 0; k < code; k++) mseed = nx(mseed);
      end else if (mleft > 0) begin
         mx = nx(mx); mleft--;
      end else if (en) begin
         if (mcnt == LEN - 1) begin
            mx = mseed; my = '1; mcnt = 0;
         end else begin
            mx = nx(mx); my = ny(my); mcnt++;
         end
      end
   endtask

   initial begin
      mx = 18'h1; my = '1; mseed = 18'h1; mcnt = 0; mleft = 0;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state is code 0, chip 0
      for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0, 9'($urandom), "R1");
      // R9: full frame of code 0 and the wrap
      cyc(1'b0, 1'b1, 9'd0, "R4");
      for (int k = 0; k < LEN + 60; k++) cyc(1'b1, 1'b0, 9'($urandom), "R9");
      // R5: longest walk, chip_en held high during it
      cyc(1'b1, 1'b1, 9'd511, "R4");
      for (int k = 0; k < 611; k++) cyc(1'b1, 1'b0, 9'd0, "R5");
      // R7: idle gap then resume
      for (int k = 0; k < 30; k++) cyc(1'b0, 1'b0, 9'($urandom), "R7");
      for (int k = 0; k < 30; k++) cyc(1'b1, 1'b0, 9'($urandom), "R7");
      // random codes, gaps, drifting code_num (R10), mid-walk restarts (R4)
      for (int t = 0; t < 24; t++) begin
         cyc(1'($urandom), 1'b1, 9'($urandom), "R4");
         if (t % 5 == 2) begin
            for (int k = 0; k < 7; k++) cyc(1'b1, 1'b0, 9'($urandom), "R10");
            cyc(1'b1, 1'b1, 9'($urandom % 4), "R4");
         end
         for (int k = 0; k < 700; k++)
            cyc(($urandom % 10) < 7, 1'b0, 9'($urandom), "R10");
      end
      // restart to code 1 and wrap a frame with gaps
      cyc(1'b0, 1'b1, 9'd1, "R4");
      for (int k = 0; k < LEN + 40; k++) cyc(($urandom % 8) != 0, 1'b0, 9'($urandom), "R9");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule